// File: doc/BRIEF.md
# Maintenance Byte Status Integrator

This block sits behind the overhead extraction of an E3 receiver. Once per received frame it is handed the maintenance-and-adaptation byte with a one-cycle valid strobe. It turns that byte into three kinds of status. The first is a remote defect state filtered for persistence. The second is a per-frame remote error pulse. The third is an integrated payload-type value, which carries change, instability and mismatch flags against an expected value that software programs.

Bit 7 of the byte is the defect bit and bit 6 is the error bit. Bits 5 down to 3 hold the payload type. Bits 2 to 0 are not used. Every status output is registered, and each one updates on the clock edge that samples the strobe. The one exception is the mismatch flag, which compares the accepted value with the expected input combinationally. A synchronous clear returns all state to its reset values.

Top module: `ma_status_integrator`

## Requirements
- R1: After reset, and in the cycle after `clr` is high, `rdi`=0, `rei_pulse`=0, `pt_q`=0, `pt_change`=0 and `pt_unstable`=0. A value of 0 is treated as the established payload type.
- R2: `rdi` rises only after 4 consecutive strobed bytes with bit 7 equal to 1. After 3 such bytes it is still 0.
- R3: `rdi` falls only after 4 consecutive strobed bytes with bit 7 equal to 0. A byte with bit 7 equal to 1 inside that run restarts the count.
- R4: `rei_pulse` is high for exactly the one cycle after a strobed byte whose bit 6 is 1. A strobed byte with bit 6 equal to 0 gives no pulse.
- R5: A payload type (bits 5:3) that differs from `pt_q` is accepted when it is seen in 5 consecutive strobed bytes. Acceptance loads `pt_q` and raises `pt_change` for one cycle.
- R6: A run of fewer than 5 identical values does not change `pt_q`, and a different value in between restarts the run. Repeating the stored value never raises `pt_change`.
- R7: `pt_unstable` sets when 5 consecutive strobed bytes pass with no value reaching 5 consecutive occurrences. It clears on the strobe where a value reaches 5 occurrences.
- R8: `pt_mismatch` is 1 exactly when `pt_q` differs from `exp_pt`, and it follows `exp_pt` without a clock delay.
- R9: When `ma_valid` is 0, `ma_byte` has no effect on any output.
- R10: `clr` is synchronous. It overrides a strobe in the same cycle and restores the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ma_byte | input | 8 | Maintenance byte of the current frame |
| ma_valid | input | 1 | One-cycle strobe marking `ma_byte` valid |
| exp_pt | input | 3 | Expected payload type |
| clr | input | 1 | Synchronous clear of all state |
| rdi | output | 1 | Filtered remote defect state |
| rei_pulse | output | 1 | One-cycle remote error pulse |
| pt_q | output | 3 | Accepted payload type |
| pt_change | output | 1 | One-cycle pulse when a new payload type is accepted |
| pt_unstable | output | 1 | No payload type is persisting |
| pt_mismatch | output | 1 | Accepted payload type differs from `exp_pt` |

## Verification
The hardest situation to reach is the unstable flag. A clean change of value never sets it, because a new value is accepted on exactly the fifth frame. The flag appears only when the stream keeps the candidate run from ever reaching five. The stimulus therefore alternates two payload values over five frames and checks that the flag is still clear after the fourth frame and set after the fifth. It then sends a steady value and checks that the flag clears on the same strobe that raises the change pulse. The defect filter is driven the same way: a single opposite bit is placed inside an otherwise qualifying run.

// File: rtl/ma_status_pkg.sv
package ma_status_pkg;
    localparam int MA_W   = 8;
    localparam int RDI_IX = 7;
    localparam int REI_IX = 6;
    localparam int PT_HI  = 5;
    localparam int PT_LO  = 3;
    localparam int PT_W   = PT_HI - PT_LO + 1;
endpackage

// File: rtl/ma_rdi_filter.sv
module ma_rdi_filter #(
    parameter int PERSIST = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic strobe,
    input  logic bit_in,
    output logic state
);
    localparam int CW = (PERSIST < 2) ? 1 : $clog2(PERSIST);

    typedef struct packed {
        logic          st;
        logic [CW-1:0] run;
    } filt_t;

    filt_t r_d, r_q;

    generate
        if (PERSIST <= 1) begin : g_direct
            always_comb begin
                r_d = r_q;
                if (clr) begin
                    r_d = '0;
                end else if (strobe) begin
                    r_d.st = bit_in;
                end
            end
        end else begin : g_count
            always_comb begin
                r_d = r_q;
                if (clr) begin
                    r_d = '0;
                end else if (strobe) begin
                    if (bit_in == r_q.st) begin
                        r_d.run = '0;
                    end else if (r_q.run == CW'(PERSIST - 1)) begin
                        r_d.st  = bit_in;
                        r_d.run = '0;
                    end else begin
                        r_d.run = r_q.run + 1'b1;
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign state = r_q.st;
endmodule

// File: rtl/ma_pt_integrator.sv
module ma_pt_integrator #(
    parameter int W        = 3,
    parameter int ACCEPT   = 5,
    parameter int UNSTABLE = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         strobe,
    input  logic [W-1:0] value,
    output logic [W-1:0] pt,
    output logic         change,
    output logic         unstable
);
    localparam int AW = $clog2(ACCEPT + 1);
    localparam int UW = $clog2(UNSTABLE + 1);

    typedef struct packed {
        logic [W-1:0]  pt;
        logic [W-1:0]  cand;
        logic [AW-1:0] run;
        logic [UW-1:0] miss;
        logic          unst;
        logic          chg;
    } integ_t;

    localparam integ_t INIT = '{pt: '0, cand: '0, run: AW'(ACCEPT),
                                miss: '0, unst: 1'b0, chg: 1'b0};

    integ_t s_d, s_q;
    logic [AW-1:0] run_next;
    logic [UW-1:0] miss_next;

    always_comb begin
        s_d       = s_q;
        s_d.chg   = 1'b0;
        run_next  = '0;
        miss_next = '0;
        if (clr) begin
            s_d = INIT;
        end else if (strobe) begin
            if (value == s_q.cand) begin
                run_next = (s_q.run == AW'(ACCEPT)) ? s_q.run : s_q.run + 1'b1;
            end else begin
                run_next = AW'(1);
            end
            s_d.cand = value;
            s_d.run  = run_next;
            if (run_next == AW'(ACCEPT)) begin
                s_d.miss = '0;
                s_d.unst = 1'b0;
                if (value != s_q.pt) begin
                    s_d.pt  = value;
                    s_d.chg = 1'b1;
                end
            end else begin
                miss_next = (s_q.miss == UW'(UNSTABLE)) ? s_q.miss : s_q.miss + 1'b1;
                s_d.miss  = miss_next;
                if (miss_next == UW'(UNSTABLE)) s_d.unst = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= INIT;
        else        s_q <= s_d;
    end

    assign pt       = s_q.pt;
    assign change   = s_q.chg;
    assign unstable = s_q.unst;
endmodule

// File: rtl/ma_status_integrator.sv
module ma_status_integrator
    import ma_status_pkg::*;
#(
    parameter int RDI_PERSIST = 4,
    parameter int PT_ACCEPT   = 5,
    parameter int PT_UNSTABLE = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [MA_W-1:0] ma_byte,
    input  logic            ma_valid,
    input  logic [PT_W-1:0] exp_pt,
    input  logic            clr,
    output logic            rdi,
    output logic            rei_pulse,
    output logic [PT_W-1:0] pt_q,
    output logic            pt_change,
    output logic            pt_unstable,
    output logic            pt_mismatch
);
    typedef struct packed {
        logic rei;
    } top_t;

    top_t t_d, t_q;

    always_comb begin
        t_d     = '0;
        t_d.rei = ma_valid && !clr && ma_byte[REI_IX];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    ma_rdi_filter #(.PERSIST(RDI_PERSIST)) i_rdi (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .strobe (ma_valid),
        .bit_in (ma_byte[RDI_IX]),
        .state  (rdi)
    );

    ma_pt_integrator #(.W(PT_W), .ACCEPT(PT_ACCEPT), .UNSTABLE(PT_UNSTABLE)) i_pt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .strobe   (ma_valid),
        .value    (ma_byte[PT_HI:PT_LO]),
        .pt       (pt_q),
        .change   (pt_change),
        .unstable (pt_unstable)
    );

    assign rei_pulse   = t_q.rei;
    assign pt_mismatch = (pt_q != exp_pt);
endmodule

// File: rtl/ma_status_checker.sv
module ma_status_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] ma_byte,
    input logic       ma_valid,
    input logic       clr,
    input logic       rdi,
    input logic       rei_pulse,
    input logic [2:0] pt_q,
    input logic       pt_change,
    input logic       pt_unstable
);
    AST_REI_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        rei_pulse |-> ($past(ma_valid) && $past(ma_byte[6]) && !$past(clr))); // R4
    AST_RDI_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ma_valid) && !$past(clr)) |-> $stable(rdi)); // R9
    AST_PT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ma_valid) && !$past(clr)) |-> $stable(pt_q)); // R9
    AST_CHANGE_MOVES_PT: assert property (@(posedge clk) disable iff (!rst_n)
        pt_change |-> (pt_q != $past(pt_q))); // R5
    AST_PT_HOLDS_WITHOUT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pt_change && !$past(clr)) |-> $stable(pt_q)); // R6
    AST_CHANGE_CLEARS_UNSTABLE: assert property (@(posedge clk) disable iff (!rst_n)
        pt_change |-> !pt_unstable); // R7
    AST_CLEAR_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!rdi && !rei_pulse && pt_q == 3'd0 && !pt_change && !pt_unstable)); // R10
endmodule

bind ma_status_integrator ma_status_checker i_ma_status_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .ma_byte     (ma_byte),
    .ma_valid    (ma_valid),
    .clr         (clr),
    .rdi         (rdi),
    .rei_pulse   (rei_pulse),
    .pt_q        (pt_q),
    .pt_change   (pt_change),
    .pt_unstable (pt_unstable)
);

// File: tb/test_ma_status_integrator.sv
module test_ma_status_integrator;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ma_byte = '0;
    logic       ma_valid = 1'b0;
    logic [2:0] exp_pt = '0;
    logic       clr = 1'b0;
    logic       rdi, rei_pulse, pt_change, pt_unstable, pt_mismatch;
    logic [2:0] pt_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ma_status_integrator i_ma_status_integrator (
        .clk(clk), .rst_n(rst_n), .ma_byte(ma_byte), .ma_valid(ma_valid),
        .exp_pt(exp_pt), .clr(clr), .rdi(rdi), .rei_pulse(rei_pulse),
        .pt_q(pt_q), .pt_change(pt_change), .pt_unstable(pt_unstable),
        .pt_mismatch(pt_mismatch)
    );

    function automatic logic [7:0] mk(input logic d, input logic e, input logic [2:0] p);
        return {d, e, p, 3'b000};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive one strobed byte; on return the outputs reflect it
    task automatic send(input logic [7:0] b);
        @(negedge clk);
        ma_byte  = b;
        ma_valid = 1'b1;
        @(negedge clk);
        ma_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rdi", rdi, 0);
        chk("R1 rei", rei_pulse, 0);
        chk("R1 pt", pt_q, 0);
        chk("R1 change", pt_change, 0);
        chk("R1 unstable", pt_unstable, 0);
    endtask

    task automatic t_rdi();
        for (int i = 0; i < 3; i++) send(mk(1, 0, 0));
        chk("R2 rdi after 3", rdi, 0);
        send(mk(1, 0, 0));
        chk("R2 rdi after 4", rdi, 1);
        for (int i = 0; i < 3; i++) send(mk(0, 0, 0));
        send(mk(1, 0, 0));
        for (int i = 0; i < 3; i++) send(mk(0, 0, 0));
        chk("R3 rdi held after broken run", rdi, 1);
        send(mk(0, 0, 0));
        chk("R3 rdi cleared after 4", rdi, 0);
    endtask

    task automatic t_rei();
        send(mk(0, 1, 0));
        chk("R4 pulse high", rei_pulse, 1);
        idle(1);
        chk("R4 pulse one cycle", rei_pulse, 0);
        send(mk(0, 0, 0));
        chk("R4 no pulse for zero", rei_pulse, 0);
    endtask

    task automatic t_accept();
        for (int i = 0; i < 4; i++) send(mk(0, 0, 5));
        chk("R6 pt after 4", pt_q, 0);
        chk("R6 no change after 4", pt_change, 0);
        send(mk(0, 0, 5));
        chk("R5 pt accepted", pt_q, 5);
        chk("R5 change pulse", pt_change, 1);
        idle(1);
        chk("R5 change one cycle", pt_change, 0);
        for (int i = 0; i < 3; i++) send(mk(0, 0, 6));
        send(mk(0, 0, 2));
        for (int i = 0; i < 4; i++) send(mk(0, 0, 6));
        chk("R6 interrupted run", pt_q, 5);
        send(mk(0, 0, 6));
        chk("R5 second accept", pt_q, 6);
        for (int i = 0; i < 6; i++) begin
            send(mk(0, 0, 6));
            chk("R6 repeat gives no change", pt_change, 0);
        end
    endtask

    task automatic t_unstable();
        send(mk(0, 0, 1)); send(mk(0, 0, 2)); send(mk(0, 0, 1)); send(mk(0, 0, 2));
        chk("R7 unstable after 4", pt_unstable, 0);
        send(mk(0, 0, 1));
        chk("R7 unstable after 5", pt_unstable, 1);
        for (int i = 0; i < 4; i++) send(mk(0, 0, 3));
        chk("R7 still unstable", pt_unstable, 1);
        send(mk(0, 0, 3));
        chk("R7 unstable cleared", pt_unstable, 0);
        chk("R7 accepted value", pt_q, 3);
    endtask

    task automatic t_mismatch();
        @(negedge clk);
        exp_pt = 3'd3;
        #1;
        chk("R8 match", pt_mismatch, 0);
        exp_pt = 3'd4;
        #1;
        chk("R8 mismatch", pt_mismatch, 1);
    endtask

    task automatic t_ignore();
        @(negedge clk);
        ma_byte = 8'hFF;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R9 rei ignored", rei_pulse, 0);
        end
        chk("R9 rdi ignored", rdi, 0);
        chk("R9 pt ignored", pt_q, 3);
    endtask

    task automatic t_clear();
        for (int i = 0; i < 4; i++) send(mk(1, 0, 4));
        send(mk(1, 0, 4));
        chk("R10 setup rdi", rdi, 1);
        chk("R10 setup pt", pt_q, 4);
        @(negedge clk);
        ma_byte = mk(1, 1, 4); ma_valid = 1'b1; clr = 1'b1;
        @(negedge clk);
        ma_valid = 1'b0; clr = 1'b0;
        chk("R10 rdi cleared", rdi, 0);
        chk("R10 pt cleared", pt_q, 0);
        chk("R10 rei suppressed", rei_pulse, 0);
        chk("R1 unstable after clear", pt_unstable, 0);
        do_clear();
        chk("R1 pt after clear", pt_q, 0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_rdi();
        t_rei();
        t_accept();
        t_unstable();
        t_mismatch();
        t_ignore();
        t_clear();
        idle(2);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule